// File: doc/BRIEF.md
# Sixteen-Bit Timer/Counter with Compare, Capture and Phase-Correct PWM

This block is a 16-bit timer/counter for a peripheral bus. The counter advances on one of two sources: a one-cycle enable pulse from an external prescaler, or the synchronized edges of an external count pin. It has three counting schemes: a free-running up count that wraps, an up count that restarts at zero after it reaches the channel A compare value, and an up/down phase-correct count for PWM. The phase-correct count turns at a TOP that is either a fixed value or is taken from the channel A compare register or the capture register.

There are two compare channels, A and B, and each one drives its own waveform output. In phase-correct mode a compare write is held in a pending register and becomes active only at TOP, so the PWM output never glitches. A capture channel takes either the capture pin or a comparator input. It can pass that input through a noise filter, and on a selected edge it stores the current count. Four sticky flags report overflow, the two compare matches and capture. Software clears a flag by writing a one to it.

Top module: `tmr16_top`

## Requirements
- R1: After reset the count, the capture register, all flags and both waveform outputs are zero.
- R2: With control bit 3 clear, the count moves one step in each cycle where `tick_en` is high. With control bit 3 set, `tick_en` is ignored and the count steps once per edge on `cnt_pin`: the rising edge when control bit 4 is 1, the falling edge when it is 0. The count changes only on a step or on a bus write to it.
- R3: In mode 0 (control bits 2:0), the count goes up by one per step and wraps from 0xFFFF to 0. The step taken at 0xFFFF sets flag bit 0.
- R4: In mode 1, a step taken while the count equals the active channel A value loads 0. Every other step adds one, including steps taken while the count is already above that value.
- R5: Modes 2 to 7 count up and down. TOP is 0x00FF, 0x01FF, 0x03FF or 0xFFFF for modes 2 to 5, the active channel A value for mode 6, and the capture register for mode 7. A step taken at TOP while counting up gives TOP-1 and reverses the direction. A step taken at 0 while counting down gives 1, reverses the direction and sets flag bit 0. Any write to the control register restarts the count direction as up.
- R6: In modes 2 to 7, a compare write goes only to the pending value. The pending value becomes active on the step taken at TOP while counting up. In modes 0 and 1, a compare write takes effect at once. A bus read of a compare address returns the pending value.
- R7: A compare match is a step taken while the count equals a channel's active value. A match sets flag bit 1 for channel A and bit 2 for channel B. On a match, modes 0 and 1 toggle that channel's output. Modes 2 to 7 clear the output on a match while counting up and set it on a match while counting down.
- R8: The capture source is `cap_pin` when control bit 5 is 0 and `cmp_in` when it is 1. The capture edge is rising when control bit 6 is 1 and falling when it is 0. On that edge the current count is copied into the capture register and flag bit 3 is set. In mode 7 capture events are ignored.
- R9: With control bit 7 set, the capture input changes level only after four consecutive equal samples. A pulse three samples long produces no capture, and a pulse four samples long does.
- R10: Writing to address 5 clears each flag whose data bit is 1 and leaves the others unchanged. Flags are never cleared any other way, and a hardware set in the same cycle wins over the clear.
- R11: Register addresses are: 0 control (bits 7:0, reads back with the upper bits zero), 1 count, 2 compare A, 3 compare B, 4 capture (software may write it), 5 flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| tick_en | input | 1 | Prescaled count enable pulse |
| cnt_pin | input | 1 | External count pin (asynchronous) |
| cap_pin | input | 1 | Capture pin (asynchronous) |
| cmp_in | input | 1 | Comparator output, alternative capture source |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| irq_flags | output | 4 | Flags: bit 0 overflow, 1 match A, 2 match B, 3 capture |

## Verification
The assertions assume that the three asynchronous pins are sampled only through the block's own synchronizers. They also assume that TOP, when it comes from a register, is never zero. A count loaded above TOP is allowed and simply runs on until it wraps. The stimulus drives bus writes and `tick_en` only on the falling clock edge and holds the pins steady for several cycles at a time. Every compare and capture value it writes is nonzero whenever that value serves as TOP.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int CNT_W  = 16;
    localparam int NFLAG  = 4;
    localparam int NCH    = 2;
    localparam int CTRL_W = 8;

    localparam logic [2:0] ADDR_CTRL = 3'd0;
    localparam logic [2:0] ADDR_CNT  = 3'd1;
    localparam logic [2:0] ADDR_CMPA = 3'd2;
    localparam logic [2:0] ADDR_CMPB = 3'd3;
    localparam logic [2:0] ADDR_CAP  = 3'd4;
    localparam logic [2:0] ADDR_FLAG = 3'd5;

    localparam int F_OVF  = 0;
    localparam int F_CMPA = 1;
    localparam int F_CAP  = 3;

    localparam logic [CNT_W-1:0] MAX_CNT = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    typedef enum logic [2:0] {
        M_NORMAL = 3'd0,
        M_CTC    = 3'd1,
        M_PC8    = 3'd2,
        M_PC9    = 3'd3,
        M_PC10   = 3'd4,
        M_PC16   = 3'd5,
        M_PC_OCA = 3'd6,
        M_PC_CAP = 3'd7
    } mode_e;

    typedef struct packed {
        logic  filt_en;
        logic  cap_rise;
        logic  cap_src;
        logic  ext_rise;
        logic  ext_clk;
        mode_e mode;
    } ctrl_t;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] cnt;
        logic             dir_dn;
        logic [CNT_W-1:0] cap;
        logic [NFLAG-1:0] flags;
    } core_st_t;

endpackage

// File: rtl/tmr16_edge_sync.sv
module tmr16_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic pulse
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // newest synchronized sample against the one before it
    assign pulse = rise_sel ? (sh_q[STAGES-1] & ~sh_q[STAGES])
                            : (~sh_q[STAGES-1] & sh_q[STAGES]);
endmodule

// File: rtl/tmr16_cap_front.sv
module tmr16_cap_front #(
    parameter int STAGES   = 2,
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic cmp_in,
    input  logic src_sel,
    input  logic rise_sel,
    input  logic filt_en,
    output logic evt
);
    typedef struct packed {
        logic [STAGES-1:0]   sync;
        logic [FILT_LEN-1:0] hist;
        logic                lvl;
        logic                evt;
    } cf_st_t;

    cf_st_t st_d, st_q;
    logic   raw, smp;

    assign raw = src_sel ? cmp_in : pin_in;
    assign smp = st_q.sync[STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], raw};
        st_d.hist = {st_q.hist[FILT_LEN-2:0], smp};
        if (!filt_en)              st_d.lvl = smp;
        else if (&st_d.hist)       st_d.lvl = 1'b1;
        else if (~|st_d.hist)      st_d.lvl = 1'b0;
        st_d.evt = rise_sel ? (st_d.lvl & ~st_q.lvl) : (~st_d.lvl & st_q.lvl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt = st_q.evt;
endmodule

// File: rtl/tmr16_cmp_chan.sv
module tmr16_cmp_chan #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         pwm_mode,
    input  logic         load,
    input  logic         step,
    input  logic         dir_dn,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] act,
    output logic [W-1:0] pend,
    output logic         hit,
    output logic         wave
);
    typedef struct packed {
        logic [W-1:0] act;
        logic [W-1:0] pend;
        logic         wave;
    } ch_st_t;

    ch_st_t st_d, st_q;

    assign hit = step && (cnt == st_q.act);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.pend = wr_data;
            if (!pwm_mode) st_d.act = wr_data;
        end
        if (pwm_mode && load) st_d.act = st_d.pend;
        if (hit) st_d.wave = pwm_mode ? dir_dn : ~st_q.wave;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act  = st_q.act;
    assign pend = st_q.pend;
    assign wave = st_q.wave;
endmodule

// File: rtl/tmr16_top.sv
module tmr16_top
    import tmr16_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [2:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             tick_en,
    input  logic             cnt_pin,
    input  logic             cap_pin,
    input  logic             cmp_in,
    output logic             wave_a,
    output logic             wave_b,
    output logic [NFLAG-1:0] irq_flags
);
    core_st_t         st_d, st_q;
    logic             ext_pulse, cap_evt, step, pwm, load, at_top;
    logic [CNT_W-1:0] top_val;
    logic [CNT_W-1:0] ocr_act  [NCH];
    logic [CNT_W-1:0] ocr_pend [NCH];
    logic [NCH-1:0]   hit, wave, ch_wr;

    tmr16_edge_sync #(.STAGES(SYNC_STAGES)) u_ext (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (cnt_pin),
        .rise_sel (st_q.ctrl.ext_rise),
        .pulse    (ext_pulse)
    );

    tmr16_cap_front #(.STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_capf (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (cap_pin),
        .cmp_in   (cmp_in),
        .src_sel  (st_q.ctrl.cap_src),
        .rise_sel (st_q.ctrl.cap_rise),
        .filt_en  (st_q.ctrl.filt_en),
        .evt      (cap_evt)
    );

    assign step   = st_q.ctrl.ext_clk ? ext_pulse : tick_en;
    assign pwm    = (st_q.ctrl.mode >= M_PC8);
    assign at_top = (st_q.cnt == top_val);
    assign load   = step && pwm && !st_q.dir_dn && at_top;

    always_comb begin
        case (st_q.ctrl.mode)
            M_PC8:    top_val = 16'h00FF;
            M_PC9:    top_val = 16'h01FF;
            M_PC10:   top_val = 16'h03FF;
            M_PC_OCA: top_val = ocr_act[0];
            M_PC_CAP: top_val = st_q.cap;
            default:  top_val = MAX_CNT;
        endcase
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign ch_wr[i] = bus_we && (bus_addr == (ADDR_CMPA + 3'(i)));
        tmr16_cmp_chan #(.W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (ch_wr[i]),
            .wr_data  (bus_wdata),
            .pwm_mode (pwm),
            .load     (load),
            .step     (step),
            .dir_dn   (st_q.dir_dn),
            .cnt      (st_q.cnt),
            .act      (ocr_act[i]),
            .pend     (ocr_pend[i]),
            .hit      (hit[i]),
            .wave     (wave[i])
        );
    end

    always_comb begin
        st_d = st_q;
        // software clear first so that hardware sets below win
        if (bus_we && bus_addr == ADDR_FLAG)
            st_d.flags = st_q.flags & ~bus_wdata[NFLAG-1:0];

        if (step) begin
            if (!pwm) begin
                if (st_q.ctrl.mode == M_CTC && st_q.cnt == ocr_act[0])
                    st_d.cnt = '0;
                else
                    st_d.cnt = st_q.cnt + ONE;
                if (st_q.cnt == MAX_CNT) st_d.flags[F_OVF] = 1'b1;
            end else if (!st_q.dir_dn) begin
                if (at_top) begin
                    st_d.dir_dn = 1'b1;
                    st_d.cnt    = st_q.cnt - ONE;
                end else begin
                    st_d.cnt    = st_q.cnt + ONE;
                end
            end else begin
                if (st_q.cnt == '0) begin
                    st_d.dir_dn      = 1'b0;
                    st_d.cnt         = ONE;
                    st_d.flags[F_OVF] = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
        end

        for (int i = 0; i < NCH; i++)
            if (hit[i]) st_d.flags[F_CMPA+i] = 1'b1;

        if (cap_evt && st_q.ctrl.mode != M_PC_CAP) begin
            st_d.cap          = st_q.cnt;
            st_d.flags[F_CAP] = 1'b1;
        end

        if (bus_we) begin
            case (bus_addr)
                ADDR_CTRL: begin
                    st_d.ctrl   = ctrl_t'(bus_wdata[CTRL_W-1:0]);
                    st_d.dir_dn = 1'b0;
                end
                ADDR_CNT: st_d.cnt = bus_wdata;
                ADDR_CAP: st_d.cap = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = CNT_W'(st_q.ctrl);
            ADDR_CNT:  bus_rdata = st_q.cnt;
            ADDR_CMPA: bus_rdata = ocr_pend[0];
            ADDR_CMPB: bus_rdata = ocr_pend[1];
            ADDR_CAP:  bus_rdata = st_q.cap;
            ADDR_FLAG: bus_rdata = CNT_W'(st_q.flags);
            default:   bus_rdata = '0;
        endcase
    end

    assign wave_a    = wave[0];
    assign wave_b    = wave[1];
    assign irq_flags = st_q.flags;
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk
    import tmr16_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [2:0]       bus_addr,
    input logic [CNT_W-1:0] bus_wdata,
    input logic             step,
    input mode_e            mode,
    input logic             dir_dn,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] act_a,
    input logic [CNT_W-1:0] act_b,
    input logic             cap_evt,
    input logic [CNT_W-1:0] cap,
    input logic [NFLAG-1:0] flags
);
    logic wr_cnt, wr_flag;
    assign wr_cnt  = bus_we && bus_addr == ADDR_CNT;
    assign wr_flag = bus_we && bus_addr == ADDR_FLAG;

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr_cnt) |=> $stable(cnt));

    p_wrap_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_NORMAL && step && cnt == MAX_CNT && !wr_cnt)
        |=> (cnt == '0 && flags[F_OVF]));

    p_ctc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_CTC && step && cnt == act_a && !wr_cnt) |=> (cnt == '0));

    p_pc_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode >= M_PC8 && dir_dn && step && cnt != '0 && !wr_cnt)
        |=> (cnt == $past(cnt) - ONE));

    p_direct_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_CMPA && mode < M_PC8) |=> (act_a == $past(bus_wdata)));

    p_direct_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_CMPB && mode < M_PC8) |=> (act_b == $past(bus_wdata)));

    p_cap_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && mode != M_PC_CAP && !(bus_we && bus_addr == ADDR_CAP))
        |=> (cap == $past(cnt) && flags[F_CAP]));

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_flag |=> ((flags & $past(flags)) == $past(flags)));
endmodule

bind tmr16_top tmr16_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .step      (step),
    .mode      (st_q.ctrl.mode),
    .dir_dn    (st_q.dir_dn),
    .cnt       (st_q.cnt),
    .act_a     (ocr_act[0]),
    .act_b     (ocr_act[1]),
    .cap_evt   (cap_evt),
    .cap       (st_q.cap),
    .flags     (st_q.flags)
);

// File: tb/tmr16_top_tb.sv
module tmr16_top_tb;
    import tmr16_pkg::*;

    logic        clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'd0, bus_rdata;
    logic        tick_en = 1'b0, cnt_pin = 1'b0, cap_pin = 1'b0, cmp_in = 1'b0;
    logic        wave_a, wave_b;
    logic [3:0]  irq_flags;
    int          checks = 0, errors = 0;
    logic [15:0] rv;

    always #10 clk = ~clk;

    tmr16_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
        .cnt_pin(cnt_pin), .cap_pin(cap_pin), .cmp_in(cmp_in),
        .wave_a(wave_a), .wave_b(wave_b), .irq_flags(irq_flags)
    );

    typedef struct packed {
        logic [2:0]  mode;
        logic [15:0] oca;
        logic [15:0] start;
        logic [7:0]  steps;
        logic [15:0] exp;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{3'd0, 16'h0000, 16'hFFFE, 8'd3, 16'h0001},  // R3 wrap
        '{3'd1, 16'h0005, 16'h0000, 8'd8, 16'h0002},  // R4 restart
        '{3'd2, 16'h0000, 16'h00FD, 8'd5, 16'h00FC},  // R5 8-bit top
        '{3'd3, 16'h0000, 16'h01FE, 8'd4, 16'h01FC},  // R5 9-bit top
        '{3'd4, 16'h0000, 16'h03FF, 8'd2, 16'h03FD},  // R5 10-bit top
        '{3'd5, 16'h0000, 16'hFFFF, 8'd1, 16'hFFFE},  // R5 16-bit top
        '{3'd6, 16'h0004, 16'h0003, 8'd6, 16'h0001},  // R5 top from A, bottom turn
        '{3'd1, 16'h0010, 16'h0020, 8'd3, 16'h0023}   // R4 count above A
    };

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic pulse_cap(input int len);
        @(negedge clk);
        cap_pin = 1'b1;
        repeat (len) @(negedge clk);
        cap_pin = 1'b0;
    endtask

    task automatic pulse_cnt(input int n);
        for (int k = 0; k < n; k++) begin
            cnt_pin = 1'b1; idle(3);
            cnt_pin = 1'b0; idle(3);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();

        // R1 reset state
        rd(ADDR_CNT, rv);  chk("R1", "count",   rv, 16'h0000);
        rd(ADDR_FLAG, rv); chk("R1", "flags",   rv, 16'h0000);
        rd(ADDR_CAP, rv);  chk("R1", "capture", rv, 16'h0000);
        chk("R1", "wave_a", 16'(wave_a), 16'd0);
        chk("R1", "wave_b", 16'(wave_b), 16'd0);

        // R3 R4 R5 vector table
        for (int i = 0; i < 8; i++) begin
            wr(ADDR_CTRL, 16'h0000);
            wr(ADDR_CMPA, VEC[i].oca);
            wr(ADDR_CNT, VEC[i].start);
            wr(ADDR_CTRL, 16'(VEC[i].mode));
            run(int'(VEC[i].steps));
            rd(ADDR_CNT, rv);
            chk(VEC[i].mode == 3'd0 ? "R3" : (VEC[i].mode == 3'd1 ? "R4" : "R5"),
                $sformatf("vector %0d count", i), rv, VEC[i].exp);
        end

        // R3 overflow flag
        do_reset();
        wr(ADDR_CNT, 16'hFFFF);
        run(1);
        rd(ADDR_CNT, rv);  chk("R3", "wrapped count", rv, 16'h0000);
        chk("R3", "overflow flag only", 16'(irq_flags), 16'h0001);

        // R11 control readback
        wr(ADDR_CTRL, 16'hAB05);
        rd(ADDR_CTRL, rv); chk("R11", "control readback", rv, 16'h0005);
        wr(ADDR_CTRL, 16'h0000);

        // R6 buffering in phase-correct mode with TOP from A
        do_reset();
        wr(ADDR_CMPA, 16'h0020);
        wr(ADDR_CTRL, 16'h0006);
        wr(ADDR_CNT, 16'h0010);
        wr(ADDR_CMPA, 16'h0008);
        rd(ADDR_CMPA, rv); chk("R6", "pending readback", rv, 16'h0008);
        run(17);
        rd(ADDR_CNT, rv);  chk("R6", "old TOP kept until TOP", rv, 16'h001F);
        run(40);
        rd(ADDR_CNT, rv);  chk("R6", "new TOP after load", rv, 16'h0007);

        // R7 phase-correct waveform on channel B
        do_reset();
        wr(ADDR_CMPA, 16'h0010);
        wr(ADDR_CMPB, 16'h0008);
        wr(ADDR_CNT, 16'h0006);
        wr(ADDR_CTRL, 16'h0006);
        run(18);
        chk("R7", "wave_b before down match", 16'(wave_b), 16'd0);
        run(1);
        chk("R7", "wave_b set on down match", 16'(wave_b), 16'd1);
        rd(ADDR_CNT, rv);  chk("R7", "count after down match", rv, 16'h0007);
        run(16);
        chk("R7", "wave_b cleared on up match", 16'(wave_b), 16'd0);
        rd(ADDR_CNT, rv);  chk("R7", "count after up match", rv, 16'h0009);
        chk("R7", "flags after cycle", 16'(irq_flags), 16'h0007);

        // R7 toggle in clear-on-compare mode
        do_reset();
        wr(ADDR_CMPA, 16'h0003);
        wr(ADDR_CTRL, 16'h0001);
        run(4);
        chk("R7", "wave_a toggled", 16'(wave_a), 16'd1);
        rd(ADDR_CNT, rv);  chk("R4", "restart at zero", rv, 16'h0000);
        run(4);
        chk("R7", "wave_a toggled back", 16'(wave_a), 16'd0);
        chk("R7", "match flags", 16'(irq_flags), 16'h0006);

        // R10 write-one-to-clear
        wr(ADDR_FLAG, 16'h0000);
        chk("R10", "zero write keeps flags", 16'(irq_flags), 16'h0006);
        wr(ADDR_FLAG, 16'h0004);
        chk("R10", "partial clear", 16'(irq_flags), 16'h0002);

        // R2 external count pin
        do_reset();
        wr(ADDR_CTRL, 16'h0018);
        tick_en = 1'b1;
        idle(5);
        pulse_cnt(3);
        tick_en = 1'b0;
        idle(5);
        rd(ADDR_CNT, rv);  chk("R2", "rising edges counted, tick ignored", rv, 16'h0003);
        wr(ADDR_CTRL, 16'h0008);
        pulse_cnt(2);
        idle(5);
        rd(ADDR_CNT, rv);  chk("R2", "falling edges counted", rv, 16'h0005);

        // R8 capture from pin, rising, one-cycle pulse
        do_reset();
        wr(ADDR_CNT, 16'h1234);
        wr(ADDR_CTRL, 16'h0040);
        idle(5);
        pulse_cap(1);
        idle(8);
        rd(ADDR_CAP, rv);  chk("R8", "pin capture value", rv, 16'h1234);
        chk("R8", "capture flag", 16'(irq_flags), 16'h0008);

        // R8 comparator source, falling edge
        cmp_in = 1'b1;
        idle(4);
        wr(ADDR_CTRL, 16'h0020);
        idle(8);
        wr(ADDR_CNT, 16'h0ABC);
        wr(ADDR_FLAG, 16'h000F);
        pulse_cap(2);
        idle(6);
        rd(ADDR_FLAG, rv); chk("R8", "pin ignored when comparator selected", rv, 16'h0000);
        cmp_in = 1'b0;
        idle(8);
        rd(ADDR_CAP, rv);  chk("R8", "comparator capture value", rv, 16'h0ABC);
        chk("R8", "comparator capture flag", 16'(irq_flags), 16'h0008);

        // R8 capture ignored in mode 7
        do_reset();
        wr(ADDR_CTRL, 16'h0047);
        wr(ADDR_CAP, 16'h0055);
        idle(5);
        pulse_cap(3);
        idle(8);
        rd(ADDR_CAP, rv);  chk("R8", "capture held in mode 7", rv, 16'h0055);
        chk("R8", "no flag in mode 7", 16'(irq_flags), 16'h0000);

        // R9 noise filter boundary
        do_reset();
        wr(ADDR_CTRL, 16'h00C0);
        wr(ADDR_CNT, 16'h0777);
        idle(8);
        pulse_cap(3);
        idle(12);
        chk("R9", "three-sample pulse rejected", 16'(irq_flags), 16'h0000);
        pulse_cap(4);
        idle(12);
        chk("R9", "four-sample pulse accepted", 16'(irq_flags), 16'h0008);
        rd(ADDR_CAP, rv);  chk("R9", "filtered capture value", rv, 16'h0777);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule